// File: doc/BRIEF.md
# Serial Segment-Image Receiver

This block is the input side of a multiplexed segment LCD driver with three common lines and thirty-two segment lines. A host sends a frame over a three-wire synchronous link made of a chip select, a serial clock and a data line. While chip select is high, the block shifts in 96 image bits. Two zero pad bits follow, and then three mode flags. When chip select drops, the complete frame is moved into holding registers in a single step. The segment image and the flags then feed the waveform generator that drives the panel.

The pins of the link are asynchronous to the system clock. Each pin passes through a two-stage synchronizer and an edge detector, so the whole block runs in one clock domain. The block counts the bits of each frame. A frame of any length other than exactly 101 bits leaves the held state unchanged. The serial clock may rest low or high between frames.

Top module: `lcd_serial_rx`

## Requirements
- R1: An active-low `rstN` clears the whole held image and all three flags to 0.
- R2: While `csIn` is low, toggles on `ckIn` and `diIn` change no output. The bit count always restarts at zero when `csIn` rises.
- R3: The bit counter stops at one step past the frame length. A frame of more than 101 bits is discarded and the outputs keep their previous values.
- R4: A frame of fewer than 101 bits is discarded and the outputs keep their previous values.
- R5: The outputs change only on a falling `csIn` that ends a valid frame. While bits are being shifted, the outputs stay stable.
- R6: `diIn` is sampled on each rising `ckIn`. Frame bit n (n = 1..96, first sent = 1) is mapped as follows, for k = 0..31: bit 3k+1 drives `segByCom[2][k]` (common 3), bit 3k+2 drives `segByCom[1][k]` (common 2), and bit 3k+3 drives `segByCom[0][k]` (common 1).
- R7: Frame bits 97 and 98 are padding. Bit 99 is `biasHalf`, bit 100 is `lowPower` and bit 101, the last bit, is `outEnable`.
- R8: Frames are received correctly whether `ckIn` rests low or high while `csIn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Frame select from the host, high during a transfer |
| ckIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data from the host |
| segByCom | output | 3x32 | Held image; row c is common c+1, column k is segment k+1 |
| biasHalf | output | 1 | Held bias-select flag |
| lowPower | output | 1 | Held low-power flag |
| outEnable | output | 1 | Held output-enable flag |

## Verification
A bit counter that is off by one would reject every legal frame, and the outputs would freeze at their reset value. A skewed shift position would move the image by one common slot, so data for common 3 would appear in the common-2 row, and the flags would pick up the pad bits. Either error shows up at the ports three system clocks after the first valid `csIn` fall. Bursts of clocks while `csIn` is low, followed by a compare of the outputs, expose any leakage from a deselected link. Frames of 100 and 102 bits test the rule that only an exact-length frame is committed.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  localparam int SEGS      = 32;
  localparam int COMS      = 3;
  localparam int PAD_BITS  = 2;
  localparam int FLAG_BITS = 3;
  localparam int DISP_BITS = SEGS * COMS;
  localparam int FRAME_BITS = DISP_BITS + PAD_BITS + FLAG_BITS;
  localparam int CNT_MAX   = FRAME_BITS + 1;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  typedef struct packed {
    logic shift;
    logic clearCnt;
    logic commit;
  } ctlStrobes_t;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= '0;
      else       chain[i] <= {chain[i][STAGES-2:0], asyncIn[i]};
    end
    assign syncOut[i] = chain[i][STAGES-1];
  end
endmodule

// File: rtl/lcdrx_ctrl.sv
module lcdrx_ctrl
  import lcdrx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csS,
  input  logic        ckS,
  output ctlStrobes_t strb
);
  logic csPrev, ckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic csRise, csFall, ckRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b0;
      ckPrev <= 1'b0;
    end else begin
      csPrev <= csS;
      ckPrev <= ckS;
    end
  end

  assign csRise = csS & ~csPrev;
  assign csFall = ~csS & csPrev;
  assign ckRise = ckS & ~ckPrev;

  always_comb begin
    strb.clearCnt = csRise;
    strb.shift    = ckRise & csS & ~csRise;
    strb.commit   = csFall & (bitCnt == CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         bitCnt <= '0;
    else if (strb.clearCnt)                            bitCnt <= '0;
    else if (strb.shift && bitCnt != CNT_W'(CNT_MAX))  bitCnt <= bitCnt + 1'b1;
  end

  // R3: a saturated count holds until the next select rise
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == CNT_W'(CNT_MAX) && !strb.clearCnt) |=> bitCnt == CNT_W'(CNT_MAX));

  // R3: below saturation each accepted clock advances the count by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.clearCnt && bitCnt < CNT_W'(CNT_MAX)) |=> bitCnt == $past(bitCnt) + 1'b1);

  // R2: a deselected link leaves the counter alone
  p_idle_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> $stable(bitCnt));
endmodule

// File: rtl/lcdrx_datapath.sv
module lcdrx_datapath
  import lcdrx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               strb,
  input  logic                      diS,
  output logic [COMS-1:0][SEGS-1:0] segByCom,
  output logic                      biasHalf,
  output logic                      lowPower,
  output logic                      outEnable
);
  logic [FRAME_BITS-1:0] shReg;
  logic [DISP_BITS-1:0]  holdDisp;
  logic [FLAG_BITS-1:0]  holdFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.shift) shReg <= {shReg[FRAME_BITS-2:0], diS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdDisp  <= '0;
      holdFlags <= '0;
    end else if (strb.commit) begin
      holdDisp  <= shReg[FRAME_BITS-1 -: DISP_BITS];
      holdFlags <= shReg[FLAG_BITS-1:0];
    end
  end

  // first bit of each triplet goes to the highest common
  for (genvar r = 0; r < COMS; r++) begin : g_row
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
      assign segByCom[r][k] = holdDisp[DISP_BITS-1-(COMS*k + (COMS-1-r))];
    end
  end

  assign biasHalf  = holdFlags[2];
  assign lowPower  = holdFlags[1];
  assign outEnable = holdFlags[0];

  // R5: held state moves only on a commit strobe
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(holdDisp) && $stable(holdFlags)));
endmodule

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx
  import lcdrx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csIn,
  input  logic                      ckIn,
  input  logic                      diIn,
  output logic [COMS-1:0][SEGS-1:0] segByCom,
  output logic                      biasHalf,
  output logic                      lowPower,
  output logic                      outEnable
);
  logic [2:0]  pinSync;
  ctlStrobes_t strb;

  lcdrx_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({csIn, ckIn, diIn}),
    .syncOut(pinSync)
  );

  lcdrx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csS(pinSync[2]), .ckS(pinSync[1]),
    .strb(strb)
  );

  lcdrx_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .diS(pinSync[0]),
    .segByCom(segByCom),
    .biasHalf(biasHalf), .lowPower(lowPower), .outEnable(outEnable)
  );
endmodule

// File: tb/lcd_serial_rx_tb.sv
module lcd_serial_rx_tb;
  import lcdrx_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0, ckIn = 1'b0, diIn = 1'b0;
  logic [COMS-1:0][SEGS-1:0] segByCom;
  logic biasHalf, lowPower, outEnable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DISP_BITS-1:0] expDisp;  // index n-1 holds bit n
  logic [2:0]           expFlags; // {bias, lowpow, oe}

  always #10 clk = ~clk;

  lcd_serial_rx u_dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .ckIn(ckIn), .diIn(diIn),
    .segByCom(segByCom), .biasHalf(biasHalf), .lowPower(lowPower), .outEnable(outEnable)
  );

  function automatic logic [COMS-1:0][SEGS-1:0] mapImage(logic [DISP_BITS-1:0] d);
    logic [COMS-1:0][SEGS-1:0] m;
    for (int k = 0; k < SEGS; k++) begin
      m[2][k] = d[3*k];
      m[1][k] = d[3*k+1];
      m[0][k] = d[3*k+2];
    end
    return m;
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(string tag);
    logic [COMS-1:0][SEGS-1:0] e;
    e = mapImage(expDisp);
    checks++;
    if (segByCom !== e || {biasHalf, lowPower, outEnable} !== expFlags) begin
      fails++;
      $display("FAIL %s: image=%h flags=%b expected image=%h flags=%b",
               tag, segByCom, {biasHalf, lowPower, outEnable}, e, expFlags);
    end
  endtask

  // sends nBits of vec, vec[nBits-1] first
  task automatic sendBits(logic [127:0] vec, int nBits, bit idleHigh, bit midCheck);
    ckIn = idleHigh;
    waitClk(3);
    csIn = 1'b1;
    waitClk(4);
    for (int i = nBits - 1; i >= 0; i--) begin
      diIn = vec[i];
      if (idleHigh) begin
        ckIn = 1'b0; waitClk(4);
        ckIn = 1'b1; waitClk(4);
      end else begin
        waitClk(2);
        ckIn = 1'b1; waitClk(4);
        ckIn = 1'b0; waitClk(2);
      end
      if (midCheck && i == 1) checkOut("R5 outputs stable while shifting");
    end
    waitClk(4);
    csIn = 1'b0;
    waitClk(8);
  endtask

  function automatic logic [127:0] buildFrame(logic [DISP_BITS-1:0] d, logic [2:0] f);
    logic [127:0] v = '0;
    for (int n = 1; n <= DISP_BITS; n++) v[FRAME_BITS - n] = d[n-1];
    v[2:0] = f;
    return v;
  endfunction

  task automatic goodFrame(logic [DISP_BITS-1:0] d, logic [2:0] f, bit idleHigh, string tag);
    sendBits(buildFrame(d, f), FRAME_BITS, idleHigh, 1'b0);
    expDisp = d; expFlags = f;
    checkOut(tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DISP_BITS-1:0] d;
    logic [2:0] f;
    void'($urandom(32'h5A17));
    expDisp = '0; expFlags = '0;
    waitClk(3);
    checkOut("R1 reset state");
    rstN = 1'b1;
    waitClk(3);

    // R6: one bit per triplet slot
    d = '0; d[0] = 1'b1;
    goodFrame(d, 3'b000, 1'b0, "R6 bit1 -> com3 seg1");
    d = '0; d[4] = 1'b1;
    goodFrame(d, 3'b000, 1'b1, "R6 bit5 -> com2 seg2");
    d = '0; d[95] = 1'b1;
    goodFrame(d, 3'b000, 1'b0, "R6 bit96 -> com1 seg32");
    // R7: each flag alone
    goodFrame('0, 3'b100, 1'b0, "R7 bias flag");
    goodFrame('0, 3'b010, 1'b1, "R7 lowpower flag");
    goodFrame('0, 3'b001, 1'b0, "R7 enable flag last");
    goodFrame('1, 3'b111, 1'b1, "R6 R8 all ones idle high");

    // random frames, alternating idle levels
    for (int t = 0; t < 6; t++) begin
      d = {$urandom, $urandom, $urandom};
      f = 3'($urandom);
      goodFrame(d, f, t[0], "R6 R7 R8 random frame");
    end

    // R5: mid-frame stability, then commit
    d = {$urandom, $urandom, $urandom}; f = 3'b101;
    sendBits(buildFrame(d, f), FRAME_BITS, 1'b0, 1'b1);
    expDisp = d; expFlags = f;
    checkOut("R5 commit after cs fall");

    // R4: short frame discarded
    sendBits(buildFrame(~d, 3'b010) >> 1, FRAME_BITS - 1, 1'b0, 1'b0);
    checkOut("R4 100-bit frame ignored");
    // R3: long frame discarded
    sendBits({buildFrame(~d, 3'b010), 1'b1}, FRAME_BITS + 1, 1'b1, 1'b0);
    checkOut("R3 102-bit frame ignored");
    sendBits({buildFrame(~d, 3'b010), 20'hFFFFF}, FRAME_BITS + 20, 1'b0, 1'b0);
    checkOut("R3 saturated long frame ignored");

    // R2: activity while deselected
    for (int i = 0; i < 30; i++) begin
      diIn = i[1]; ckIn = ~ckIn; waitClk(4);
    end
    ckIn = 1'b0;
    waitClk(6);
    checkOut("R2 deselected clocks ignored");
    d = {$urandom, $urandom, $urandom};
    goodFrame(d, 3'b011, 1'b0, "R2 count restarts at cs rise");

    // R1: reset after data
    rstN = 1'b0;
    waitClk(2);
    expDisp = '0; expFlags = '0;
    checkOut("R1 reset clears held data");
    rstN = 1'b1;
    waitClk(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule